// File: doc/BRIEF.md
# Video DRAM Write Cycle Classifier

This block observes the five asynchronous control strobes of a video DRAM: the active-low row strobe, column strobe and write enable, the active-low transfer/output enable, and an active-high special-function select. Each strobe passes through a two-flop synchronizer into the system clock domain, and edges are detected on the synchronized levels. When the row strobe falls, the levels of the other strobes select the cycle family: a normal RAM read/write cycle (no-mask or masked), a colour register load cycle, or an unrecognized "other" cycle. The family code is held until the row strobe rises.

Inside a RAM read/write family, each column strobe access is classified independently, so page-mode bursts are supported. If write enable is already low when the column strobe falls, the access is an early write, and the block requests that the data I/O be put in high impedance. If write enable falls while the column strobe is low, the block compares the elapsed clock cycles against two programmable minimum delays, column-to-write and address-to-write. Below either minimum the access is a delayed write. Once both minimums are met it is a read-modify-write. An access that ends without write enable falling is a read. Every final classification is marked by a one-cycle strobe.

Top module: `vdram_cycle_classifier`

## Requirements
- R1: After reset, `family` is 00, `write_kind` is 00, and `io_hiz` and `class_valid` are 0.
- R2: At a row strobe fall with column strobe high, transfer/output enable high and special function low, `family` becomes 01 (RAM read/write). `mask_wr` becomes 1 if write enable was low at that fall and 0 if it was high.
- R3: At a row strobe fall with column strobe, transfer/output enable and write enable all high and special function high, `family` becomes 10 (colour load). No `class_valid` pulse occurs during that row cycle.
- R4: Any other strobe combination at a row strobe fall gives `family` 11. No `class_valid` pulse occurs during that row cycle.
- R5: After the row strobe rises, `family` returns to 00, and `write_kind`, `mask_wr` and `io_hiz` return to 0.
- R6: In family 01, write enable low at the synchronized column strobe fall gives `write_kind` 01 (early) with a `class_valid` pulse. `io_hiz` is 1 from then until the column strobe rises.
- R7: In family 01, write enable falling while the column strobe is low, after fewer than max(`COL_WR_DLY`, `ADR_WR_DLY`) cycles, gives `write_kind` 10 (delayed) with a pulse, and `io_hiz` stays 0.
- R8: In family 01, write enable falling at least `COL_WR_DLY` cycles and at least `ADR_WR_DLY` cycles after the column strobe fell gives `write_kind` 11 (read-modify-write) with a pulse. The count is taken between the synchronized edges.
- R9: In family 01, a column strobe rise with no write enable fall during the access gives a pulse with `write_kind` 00 (read).
- R10: Within one row cycle, each column access is classified on its own. `write_kind` is cleared to 00 at each new column strobe fall, and `family` is held.
- R11: Every strobe change reaches the outputs on the third rising clock edge after it is applied, and not earlier.
- R12: `class_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Asynchronous row strobe, active low |
| col_stb_n | input | 1 | Asynchronous column strobe, active low |
| wr_en_n | input | 1 | Asynchronous write enable, active low |
| xfer_oe_n | input | 1 | Asynchronous transfer/output enable, active low |
| spec_fn | input | 1 | Asynchronous special-function select |
| family | output | 2 | Cycle family: 00 idle, 01 RAM, 10 colour load, 11 other |
| mask_wr | output | 1 | Masked write selected at row strobe fall |
| write_kind | output | 2 | 00 none/read, 01 early, 10 delayed, 11 read-modify-write |
| class_valid | output | 1 | One-cycle strobe when a classification is final |
| io_hiz | output | 1 | Request to place data I/O in high impedance |

## Verification
The bench places write enable falls at 3, 5, 6 and 8 cycles after the column strobe, with default minimums of 6 and 4. The 5-cycle case meets the address-to-write minimum but not the column-to-write minimum. A design that tests only one minimum, or that uses the smaller of the two, would report read-modify-write there. A design with an off-by-one compare would misclassify the 6-cycle boundary. Page-mode bursts mix early writes, reads and read-modify-writes in one row cycle, which catches a design that fails to clear the write kind or that keeps the I/O in high impedance after the column strobe rises. Colour and "other" cycles are driven with write activity, so a design that classifies outside the RAM family would emit spurious strobes. A latency probe one edge before the expected change catches a missing or extra synchronizer stage.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

  typedef enum logic [1:0] {
    FAM_NONE  = 2'b00,
    FAM_RAM   = 2'b01,
    FAM_COLOR = 2'b10,
    FAM_OTHER = 2'b11
  } fam_e;

  typedef enum logic [1:0] {
    WK_NONE    = 2'b00,
    WK_EARLY   = 2'b01,
    WK_DELAYED = 2'b10,
    WK_RMW     = 2'b11
  } kind_e;

  // strobe vector bit positions
  localparam int IX_ROW  = 0;
  localparam int IX_COL  = 1;
  localparam int IX_WE   = 2;
  localparam int IX_XOE  = 3;
  localparam int IX_SPEC = 4;
  localparam int NSTB    = 5;
  // idle levels: active-low strobes high, special function low
  localparam logic [NSTB-1:0] STB_IDLE = 5'b01111;

  function automatic fam_e decode_family(input logic col_hi, input logic xoe_hi,
                                         input logic we_hi, input logic spec_hi);
    if (col_hi && xoe_hi && !spec_hi)
      return FAM_RAM;
    if (col_hi && xoe_hi && we_hi && spec_hi)
      return FAM_COLOR;
    return FAM_OTHER;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // true once the elapsed count satisfies both minimum delays
  function automatic logic rmw_reached(input int elapsed, input int col_dly,
                                       input int adr_dly);
    return (elapsed >= col_dly) && (elapsed >= adr_dly);
  endfunction

endpackage

// File: rtl/vcc_strobe_sync.sv
module vcc_strobe_sync #(
  parameter int N = 5,
  parameter logic [N-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign lvl[i] = s2;
    assign prv[i] = s3;
  end
endmodule

// File: rtl/vcc_family_decode.sv
module vcc_family_decode
  import vcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic row_fall,
  input  logic row_rise,
  input  logic col_hi,
  input  logic xoe_hi,
  input  logic we_hi,
  input  logic spec_hi,
  output fam_e fam,
  output logic masked
);
  fam_e next_fam;
  assign next_fam = decode_family(col_hi, xoe_hi, we_hi, spec_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fam    <= FAM_NONE;
      masked <= 1'b0;
    end else if (row_fall) begin
      fam    <= next_fam;
      masked <= (next_fam == FAM_RAM) && !we_hi;
    end else if (row_rise) begin
      fam    <= FAM_NONE;
      masked <= 1'b0;
    end
  end
endmodule

// File: rtl/vcc_access_classifier.sv
module vcc_access_classifier
  import vcc_pkg::*;
#(
  parameter int COL_WR_DLY = 6,
  parameter int ADR_WR_DLY = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ram_family,
  input  logic  row_rise,
  input  logic  col_fall,
  input  logic  col_rise,
  input  logic  we_fall,
  input  logic  we_hi,
  output kind_e kind,
  output logic  valid,
  output logic  hiz
);
  localparam int MAXD = max2(COL_WR_DLY, ADR_WR_DLY);
  localparam int CW   = $clog2(MAXD + 2) + 1;
  localparam logic [CW-1:0] CNT_SAT = CW'(MAXD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} st_e;
  st_e st;
  logic [CW-1:0] cnt;
  logic rmw_now;

  assign rmw_now = rmw_reached(int'(cnt), COL_WR_DLY, ADR_WR_DLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      kind  <= WK_NONE;
      valid <= 1'b0;
      hiz   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (row_rise || !ram_family) begin
        st   <= ST_IDLE;
        kind <= WK_NONE;
        hiz  <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (col_fall) begin
            if (!we_hi) begin
              kind  <= WK_EARLY;
              valid <= 1'b1;
              hiz   <= 1'b1;
              st    <= ST_DONE;
            end else begin
              kind <= WK_NONE;
              hiz  <= 1'b0;
              cnt  <= CW'(1);
              st   <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (col_rise) begin
              kind  <= WK_NONE;
              valid <= 1'b1;
              st    <= ST_IDLE;
            end else if (we_fall) begin
              kind  <= rmw_now ? WK_RMW : WK_DELAYED;
              valid <= 1'b1;
              st    <= ST_DONE;
            end else if (cnt != CNT_SAT) begin
              cnt <= cnt + CW'(1);
            end
          end
          ST_DONE: if (col_rise) begin
            hiz <= 1'b0;
            st  <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/vdram_cycle_classifier.sv
module vdram_cycle_classifier
  import vcc_pkg::*;
#(
  parameter int COL_WR_DLY = 6,
  parameter int ADR_WR_DLY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_stb_n,
  input  logic       col_stb_n,
  input  logic       wr_en_n,
  input  logic       xfer_oe_n,
  input  logic       spec_fn,
  output logic [1:0] family,
  output logic       mask_wr,
  output logic [1:0] write_kind,
  output logic       class_valid,
  output logic       io_hiz
);
  localparam int RMW_THR = max2(COL_WR_DLY, ADR_WR_DLY);

  logic [NSTB-1:0] stb_raw, lvl, prv;
  assign stb_raw[IX_ROW]  = row_stb_n;
  assign stb_raw[IX_COL]  = col_stb_n;
  assign stb_raw[IX_WE]   = wr_en_n;
  assign stb_raw[IX_XOE]  = xfer_oe_n;
  assign stb_raw[IX_SPEC] = spec_fn;

  vcc_strobe_sync #(.N(NSTB), .RST_VAL(STB_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(stb_raw), .lvl(lvl), .prv(prv)
  );

  // named events, also observed by the checker
  logic row_fall_w, row_rise_w, cas_fall_w, cas_rise_w, we_fall_w, ras_prev_w;
  assign row_fall_w = prv[IX_ROW] && !lvl[IX_ROW];
  assign row_rise_w = !prv[IX_ROW] && lvl[IX_ROW];
  assign cas_fall_w = prv[IX_COL] && !lvl[IX_COL];
  assign cas_rise_w = !prv[IX_COL] && lvl[IX_COL];
  assign we_fall_w  = prv[IX_WE] && !lvl[IX_WE];
  assign ras_prev_w = prv[IX_ROW];

  wire unused_ok = ^{prv[IX_XOE], prv[IX_SPEC]};

  fam_e  fam_q;
  kind_e kind_q;

  vcc_family_decode u_fam (
    .clk(clk), .rst_n(rst_n),
    .row_fall(row_fall_w), .row_rise(row_rise_w),
    .col_hi(lvl[IX_COL]), .xoe_hi(lvl[IX_XOE]),
    .we_hi(lvl[IX_WE]), .spec_hi(lvl[IX_SPEC]),
    .fam(fam_q), .masked(mask_wr)
  );

  vcc_access_classifier #(.COL_WR_DLY(COL_WR_DLY), .ADR_WR_DLY(ADR_WR_DLY)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .ram_family(fam_q == FAM_RAM), .row_rise(row_rise_w),
    .col_fall(cas_fall_w), .col_rise(cas_rise_w),
    .we_fall(we_fall_w), .we_hi(lvl[IX_WE]),
    .kind(kind_q), .valid(class_valid), .hiz(io_hiz)
  );

  assign family     = fam_q;
  assign write_kind = kind_q;
endmodule

// File: rtl/vcc_checker.sv
module vcc_checker #(
  parameter int THR = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] family,
  input logic [1:0] write_kind,
  input logic       class_valid,
  input logic       io_hiz,
  input logic       cas_fall_w,
  input logic       ras_prev_w
);
  localparam int CW = $clog2(THR + 3) + 1;
  localparam logic [CW-1:0] SAT = CW'(THR + 2);
  logic [CW-1:0] since_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_cas <= '0;
    else if (cas_fall_w) since_cas <= CW'(1);
    else if (since_cas != SAT && since_cas != '0) since_cas <= since_cas + CW'(1);
  end

  AST_HIZ_ONLY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    io_hiz |-> write_kind == 2'b01); // R6
  AST_KIND_NEEDS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    write_kind != 2'b00 |-> family == 2'b01); // R4
  AST_IDLE_WHEN_ROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ras_prev_w |-> family == 2'b00); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    class_valid |=> !class_valid); // R12
  AST_RMW_LATE_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (class_valid && write_kind == 2'b11) |-> since_cas >= CW'(THR + 1)); // R8
  AST_DELAYED_EARLY_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (class_valid && write_kind == 2'b10) |-> since_cas <= CW'(THR)); // R7
endmodule

bind vdram_cycle_classifier vcc_checker #(.THR(RMW_THR)) u_chk (
  .clk(clk), .rst_n(rst_n), .family(family), .write_kind(write_kind),
  .class_valid(class_valid), .io_hiz(io_hiz),
  .cas_fall_w(cas_fall_w), .ras_prev_w(ras_prev_w)
);

// File: tb/tb_vdram_cycle_classifier.sv
`timescale 1ns/1ps
module tb_vdram_cycle_classifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1, xfer_oe_n = 1'b1, spec_fn = 1'b0;
  logic [1:0] family, write_kind;
  logic mask_wr, class_valid, io_hiz;

  always #4 clk = ~clk;

  vdram_cycle_classifier dut (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .xfer_oe_n(xfer_oe_n), .spec_fn(spec_fn),
    .family(family), .mask_wr(mask_wr), .write_kind(write_kind),
    .class_valid(class_valid), .io_hiz(io_hiz)
  );

  int n_chk = 0, n_fail = 0;
  int pulses = 0, back_to_back = 0;
  logic [1:0] last_kind = 2'b00;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  // pulse monitor, sampled 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (class_valid) begin
      pulses++;
      last_kind = write_kind;
      if (prev_valid) back_to_back++;
    end
    prev_valid = class_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_row(input logic we, input logic xoe, input logic spec, input logic col);
    wr_en_n = we; xfer_oe_n = xoe; spec_fn = spec; col_stb_n = col;
    cyc(1);
    row_stb_n = 1'b0;
    cyc(3);
  endtask

  task automatic close_row();
    col_stb_n = 1'b1; wr_en_n = 1'b1; xfer_oe_n = 1'b1; spec_fn = 1'b0;
    cyc(1);
    row_stb_n = 1'b1;
    cyc(3);
    chk(family == 2'b00, "R5 family", family, 0);
    chk(write_kind == 2'b00 && !io_hiz && !mask_wr, "R5 cleared",
        {write_kind, io_hiz, mask_wr}, 0);
  endtask

  task automatic t_reset();
    chk(family == 2'b00 && write_kind == 2'b00, "R1 codes", {family, write_kind}, 0);
    chk(!io_hiz && !class_valid, "R1 flags", {io_hiz, class_valid}, 0);
  endtask

  task automatic t_latency();
    wr_en_n = 1'b1; cyc(1);
    row_stb_n = 1'b0;
    cyc(2);
    chk(family == 2'b00, "R11 not before third edge", family, 0);
    cyc(1);
    chk(family == 2'b01, "R11 at third edge", family, 1);
    chk(!mask_wr, "R2 no-mask", mask_wr, 0);
    close_row();
  endtask

  task automatic t_early();
    int p0;
    open_row(1'b1, 1'b1, 1'b0, 1'b1);
    wr_en_n = 1'b0; cyc(2);
    p0 = pulses;
    col_stb_n = 1'b0; cyc(3);
    chk(pulses == p0 + 1 && write_kind == 2'b01, "R6 early kind",
        write_kind, 1);
    chk(io_hiz, "R6 hiz during access", io_hiz, 1);
    col_stb_n = 1'b1; cyc(3);
    chk(!io_hiz, "R6 hiz released", io_hiz, 0);
    chk(pulses == p0 + 1, "R6 single classification", pulses - p0, 1);
    close_row();
  endtask

  task automatic t_late_we(input int d, input logic [1:0] exp, input string req);
    int p0;
    open_row(1'b1, 1'b1, 1'b0, 1'b1);
    p0 = pulses;
    col_stb_n = 1'b0;
    cyc(d);
    wr_en_n = 1'b0;
    cyc(3);
    chk(pulses == p0 + 1, req, pulses - p0, 1);
    chk(last_kind == exp && write_kind == exp, req, last_kind, exp);
    chk(!io_hiz, req, io_hiz, 0);
    close_row();
  endtask

  task automatic t_read();
    int p0;
    open_row(1'b1, 1'b1, 1'b0, 1'b1);
    p0 = pulses;
    col_stb_n = 1'b0; cyc(4);
    chk(pulses == p0, "R9 no pulse while open", pulses - p0, 0);
    col_stb_n = 1'b1; cyc(3);
    chk(pulses == p0 + 1 && last_kind == 2'b00, "R9 read", last_kind, 0);
    close_row();
  endtask

  task automatic t_page();
    int p0;
    open_row(1'b1, 1'b1, 1'b0, 1'b1);
    p0 = pulses;
    wr_en_n = 1'b0; col_stb_n = 1'b0; cyc(3);
    chk(write_kind == 2'b01, "R10 page early", write_kind, 1);
    col_stb_n = 1'b1; wr_en_n = 1'b1; cyc(3);
    col_stb_n = 1'b0; cyc(3);
    chk(write_kind == 2'b00, "R10 cleared at column fall", write_kind, 0);
    cyc(5);
    wr_en_n = 1'b0; cyc(3);
    chk(write_kind == 2'b11, "R10 page rmw", write_kind, 3);
    col_stb_n = 1'b1; wr_en_n = 1'b1; cyc(3);
    col_stb_n = 1'b0; cyc(2);
    col_stb_n = 1'b1; cyc(3);
    chk(pulses == p0 + 3 && last_kind == 2'b00, "R10 page read", pulses - p0, 3);
    chk(family == 2'b01, "R10 family held", family, 1);
    close_row();
  endtask

  task automatic t_masked();
    open_row(1'b0, 1'b1, 1'b0, 1'b1);
    chk(family == 2'b01 && mask_wr, "R2 masked", {family, mask_wr}, 3);
    close_row();
  endtask

  task automatic t_quiet(input logic xoe, input logic spec, input logic [1:0] exp_fam,
                         input string req);
    int p0;
    open_row(1'b1, xoe, spec, 1'b1);
    chk(family == exp_fam, req, family, exp_fam);
    p0 = pulses;
    wr_en_n = 1'b0; col_stb_n = 1'b0; cyc(3);
    col_stb_n = 1'b1; wr_en_n = 1'b1; cyc(3);
    col_stb_n = 1'b0; cyc(7);
    wr_en_n = 1'b0; cyc(3);
    col_stb_n = 1'b1; cyc(3);
    chk(pulses == p0 && write_kind == 2'b00, req, pulses - p0, 0);
    close_row();
  endtask

  initial begin
    #100000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_latency();
    t_early();
    t_late_we(3, 2'b10, "R7 delayed d3");
    t_late_we(5, 2'b10, "R7 delayed d5");
    t_late_we(6, 2'b11, "R8 rmw d6");
    t_late_we(8, 2'b11, "R8 rmw d8");
    t_read();
    t_page();
    t_masked();
    t_quiet(1'b1, 1'b1, 2'b10, "R3 colour");
    t_quiet(1'b0, 1'b0, 2'b11, "R4 other");
    chk(back_to_back == 0, "R12 single-cycle pulse", back_to_back, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule